// File: doc/BRIEF.md
# Oscilloscope Vertical Channel Sequencer

This block chooses which vertical signal path feeds the display of a two-channel oscilloscope. It takes six front-panel mode buttons, a system clock and the alternate-sweep pulse from the horizontal logic. From these it produces active-high enables for channel A, channel B and the trigger-view path, and a flag that marks summing mode. Only the digital enable sequencing is built here. The analog switches, the summing amplifier and the blanking sit outside the block.

In the two sequencing modes the block steps through the paths from one of two sources. The first is an internal chopper tick, made by dividing the system clock by `CHOP_DIV`. The default of 100 gives about 500 kHz from 50 MHz. The second is the rising edge of the alternate-sweep pulse. The sequence is A, B, A, B and so on. When the trigger-view button is also pressed, the sequence becomes A, B, trigger, A and so on. In summing mode, A and B are held open together.

The button inputs are decoded into one of eight modes. The decoded mode and the sequence phase are both registered, so every output changes one clock edge after the inputs that cause it.

Top module: `vchan_sequencer`

## Requirements
- R1: All outputs are active high. A synchronous reset, held at a clock edge, leaves only `enA` high after that edge.
- R2: With no mode button pressed and exactly one of `btnA`, `btnB` or `btnTrig` pressed, only the matching enable is high after the next edge.
- R3: With no mode button pressed and none, two or three of the select buttons pressed, the block falls back to `enA` alone.
- R4: While `btnAdd` is pressed, `enA`, `enB` and `addOn` are high and `enTrig` is low after the next edge, whatever the other buttons are. Outside summing mode, `addOn` is low.
- R5: In chop mode (`btnChop`, no `btnAlt`, no `btnAdd`, no `btnTrig`), the enables alternate between A and B. The first step comes `CHOP_DIV` edges after the mode is entered, and each later step comes `CHOP_DIV` edges after the one before. `enTrig` stays low.
- R6: In chop mode with `btnTrig` pressed, the chopper tick rotates the enables through A, B and trigger in that order, with exactly one high at a time.
- R7: In alternate mode (`btnAlt`, no `btnAdd`), each rising edge of `altPulse` advances the sequence by one step, at the edge where `altPulse` is first sampled high. A pulse held high for several cycles gives only one step, and the chopper tick has no effect.
- R8: In alternate mode with `btnTrig` pressed, the pulses rotate the enables through A, B and trigger in that order.
- R9: Mode priority is summing, then alternate, then chop, then the single selections. With both `btnAlt` and `btnChop` pressed, only `altPulse` steps the sequence.
- R10: Any change of the decoded mode restarts the sequence at channel A at that edge. A step that falls on the same edge is dropped. Outside summing mode, exactly one enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btnA | input | 1 | Select channel A |
| btnB | input | 1 | Select channel B |
| btnTrig | input | 1 | Select trigger-view path |
| btnChop | input | 1 | Chop sequencing mode |
| btnAlt | input | 1 | Alternate sequencing mode |
| btnAdd | input | 1 | Summing mode |
| altPulse | input | 1 | Alternate-sweep pulse from the horizontal logic |
| enA | output | 1 | Channel A path enable |
| enB | output | 1 | Channel B path enable |
| enTrig | output | 1 | Trigger-view path enable |
| addOn | output | 1 | Summing mode indication |

## Verification
A sequence step and a mode restart can fall on the same clock edge. The step comes from a chopper tick or a rising `altPulse` edge. The restart comes from a change of buttons. The bench provokes this collision in two ways. In alternate mode it raises `altPulse` in the same cycle that it toggles `btnTrig`. In chop mode it toggles `btnTrig` in exactly the cycle where the divider would fire. In both cases channel A alone must follow, and the next step must come only after a fresh edge or a full `CHOP_DIV` period.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [2:0] {
    MD_A     = 3'd0,
    MD_B     = 3'd1,
    MD_T     = 3'd2,
    MD_ADD   = 3'd3,
    MD_ALT2  = 3'd4,
    MD_ALT3  = 3'd5,
    MD_CHOP2 = 3'd6,
    MD_CHOP3 = 3'd7
  } modeE;

  typedef struct packed {
    logic restart;
    logic step;
    logic threeWay;
  } seqCtlS;

  localparam logic [1:0] PH_A = 2'd0;
  localparam logic [1:0] PH_B = 2'd1;
  localparam logic [1:0] PH_T = 2'd2;

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int CHOP_DIV = 100
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   btnA,
  input  logic   btnB,
  input  logic   btnTrig,
  input  logic   btnChop,
  input  logic   btnAlt,
  input  logic   btnAdd,
  input  logic   altPulse,
  output seqCtlS ctl,
  output modeE   modeQ
);

  localparam int CW = (CHOP_DIV > 1) ? $clog2(CHOP_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHOP_DIV - 1);

  modeE modeNow;
  logic altPrev;
  logic altRise;
  logic chopRun;
  logic chopTick;
  logic restart;
  logic [1:0] selCount;

  assign selCount = 2'(btnA) + 2'(btnB) + 2'(btnTrig);

  always_comb begin
    if (btnAdd) begin
      modeNow = MD_ADD;
    end else if (btnAlt) begin
      modeNow = btnTrig ? MD_ALT3 : MD_ALT2;
    end else if (btnChop) begin
      modeNow = btnTrig ? MD_CHOP3 : MD_CHOP2;
    end else if (selCount == 2'd1) begin
      if (btnB)         modeNow = MD_B;
      else if (btnTrig) modeNow = MD_T;
      else              modeNow = MD_A;
    end else begin
      modeNow = MD_A;
    end
  end

  assign restart = (modeNow != modeQ);
  assign chopRun = (modeNow == MD_CHOP2) || (modeNow == MD_CHOP3);

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ   <= MD_A;
      altPrev <= 1'b0;
    end else begin
      modeQ   <= modeNow;
      altPrev <= altPulse;
    end
  end

  assign altRise = altPulse && !altPrev;

  generate
    if (CHOP_DIV <= 1) begin : g_tickEvery
      assign chopTick = chopRun && !restart;
    end else begin : g_tickDiv
      logic [CW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (rst || restart || !chopRun) begin
          divCnt <= '0;
        end else if (divCnt == LAST) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign chopTick = chopRun && !restart && (divCnt == LAST);
    end
  endgenerate

  always_comb begin
    ctl.restart  = restart;
    ctl.threeWay = (modeNow == MD_ALT3) || (modeNow == MD_CHOP3);
    ctl.step     = chopTick ||
                   (!restart && altRise &&
                    ((modeNow == MD_ALT2) || (modeNow == MD_ALT3)));
  end

endmodule

// File: rtl/vseq_path.sv
module vseq_path
  import vseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  seqCtlS ctl,
  input  modeE   modeQ,
  output logic   enA,
  output logic   enB,
  output logic   enTrig,
  output logic   addOn
);

  logic [1:0] phase;
  logic [1:0] phaseNext;

  always_comb begin
    unique case (phase)
      PH_A:    phaseNext = PH_B;
      PH_B:    phaseNext = ctl.threeWay ? PH_T : PH_A;
      default: phaseNext = PH_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.restart) begin
      phase <= PH_A;
    end else if (ctl.step) begin
      phase <= phaseNext;
    end
  end

  always_comb begin
    enA    = 1'b0;
    enB    = 1'b0;
    enTrig = 1'b0;
    addOn  = 1'b0;
    unique case (modeQ)
      MD_ADD: begin
        enA   = 1'b1;
        enB   = 1'b1;
        addOn = 1'b1;
      end
      MD_B: enB    = 1'b1;
      MD_T: enTrig = 1'b1;
      MD_ALT2, MD_ALT3, MD_CHOP2, MD_CHOP3: begin
        enA    = (phase == PH_A);
        enB    = (phase == PH_B);
        enTrig = (phase == PH_T);
      end
      default: enA = 1'b1;
    endcase
  end

endmodule

// File: rtl/vchan_sequencer.sv
module vchan_sequencer
  import vseq_pkg::*;
#(
  parameter int CHOP_DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic btnA,
  input  logic btnB,
  input  logic btnTrig,
  input  logic btnChop,
  input  logic btnAlt,
  input  logic btnAdd,
  input  logic altPulse,
  output logic enA,
  output logic enB,
  output logic enTrig,
  output logic addOn
);

  seqCtlS ctl;
  modeE   modeQ;

  vseq_ctrl #(.CHOP_DIV(CHOP_DIV)) u_ctrl (
    .clk(clk), .rst(rst),
    .btnA(btnA), .btnB(btnB), .btnTrig(btnTrig),
    .btnChop(btnChop), .btnAlt(btnAlt), .btnAdd(btnAdd),
    .altPulse(altPulse),
    .ctl(ctl), .modeQ(modeQ)
  );

  vseq_path u_path (
    .clk(clk), .rst(rst),
    .ctl(ctl), .modeQ(modeQ),
    .enA(enA), .enB(enB), .enTrig(enTrig), .addOn(addOn)
  );

endmodule

// File: rtl/vseq_chk.sv
module vseq_chk (
  input logic clk,
  input logic rst,
  input logic btnA,
  input logic btnB,
  input logic btnTrig,
  input logic btnChop,
  input logic btnAlt,
  input logic btnAdd,
  input logic altPulse,
  input logic enA,
  input logic enB,
  input logic enTrig,
  input logic addOn
);

  logic [5:0] btns;
  logic [5:0] prevBtn;
  logic prevAlt;
  logic primed;
  logic holdAlt;
  logic trigFlip;

  assign btns = {btnA, btnB, btnTrig, btnChop, btnAlt, btnAdd};

  always_ff @(posedge clk) begin
    if (rst) begin
      prevBtn <= '0;
      prevAlt <= 1'b0;
      primed  <= 1'b0;
    end else begin
      prevBtn <= btns;
      prevAlt <= altPulse;
      primed  <= 1'b1;
    end
  end

  assign holdAlt  = primed && btnAlt && !btnAdd && (btns == prevBtn) &&
                    !(altPulse && !prevAlt);
  assign trigFlip = primed && (btnAlt || btnChop) && !btnAdd &&
                    (btnTrig != prevBtn[3]);

  assert_reset_a_R1: assert property (@(posedge clk)
    rst |=> (enA && !enB && !enTrig && !addOn));

  assert_add_both_R4: assert property (@(posedge clk) disable iff (rst)
    btnAdd |=> (enA && enB && !enTrig && addOn));

  assert_chop_notrig_R5: assert property (@(posedge clk) disable iff (rst)
    (btnChop && !btnAlt && !btnAdd && !btnTrig) |=> !enTrig);

  assert_alt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    holdAlt |=> $stable({enA, enB, enTrig, addOn}));

  assert_restart_a_R10: assert property (@(posedge clk) disable iff (rst)
    trigFlip |=> (enA && !enB && !enTrig));

  assert_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    !addOn |-> ($countones({enA, enB, enTrig}) == 1));

endmodule

bind vchan_sequencer vseq_chk u_chk (.*);

// File: tb/test_vchan_sequencer.sv
module test_vchan_sequencer;

  localparam int DIV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnA = 0, btnB = 0, btnTrig = 0, btnChop = 0, btnAlt = 0, btnAdd = 0;
  logic altPulse = 0;
  logic enA, enB, enTrig, addOn;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int steps  = 0;

  always #2.5 clk = ~clk;

  vchan_sequencer #(.CHOP_DIV(DIV)) i_vchan_sequencer (
    .clk(clk), .rst(rst),
    .btnA(btnA), .btnB(btnB), .btnTrig(btnTrig),
    .btnChop(btnChop), .btnAlt(btnAlt), .btnAdd(btnAdd),
    .altPulse(altPulse),
    .enA(enA), .enB(enB), .enTrig(enTrig), .addOn(addOn)
  );

  task automatic expect4(input logic a, b, t, ad, input string req);
    checks++;
    if ({enA, enB, enTrig, addOn} !== {a, b, t, ad}) begin
      fails++;
      $display("FAIL %s: got A/B/T/add=%b%b%b%b expected %b%b%b%b",
               req, enA, enB, enTrig, addOn, a, b, t, ad);
    end
  endtask

  // phase 0 = A, 1 = B, 2 = trigger
  task automatic expectPhase(input int ph, input string req);
    expect4(ph == 0, ph == 1, ph == 2, 1'b0, req);
  endtask

  task automatic setBtn(input logic a, b, t, c, al, ad);
    btnA = a; btnB = b; btnTrig = t; btnChop = c; btnAlt = al; btnAdd = ad;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one pulse of length len high, gap low; checks every cycle
  task automatic altBurst(input int len, input int gap, input int nPath,
                          input string req);
    @(negedge clk);
    altPulse = 1'b1;
    for (int i = 0; i < len; i++) begin
      tick();
      if (i == 0) steps++;
      expectPhase(steps % nPath, req);
      @(negedge clk);
    end
    altPulse = 1'b0;
    for (int i = 0; i < gap; i++) begin
      tick();
      expectPhase(steps % nPath, req);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(); tick();
    expect4(1, 0, 0, 0, "R1 reset");
    @(negedge clk); rst = 1'b0;

    // R2 / R3 single selections, all 8 combinations
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      setBtn(s[2], s[1], s[0], 0, 0, 0);
      tick();
      if (s == 4)      expect4(1, 0, 0, 0, "R2 single A");
      else if (s == 2) expect4(0, 1, 0, 0, "R2 single B");
      else if (s == 1) expect4(0, 0, 1, 0, "R2 single trig");
      else             expect4(1, 0, 0, 0, "R3 fallback A");
    end

    // R4 / R9 summing wins over every other button pattern
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      setBtn(s[4], s[3], s[2], s[1], s[0], 1);
      altPulse = s[0];
      tick();
      expect4(1, 1, 0, 1, "R4 add priority R9");
    end
    @(negedge clk); altPulse = 0;

    // R5 chop two-way, entered from single B
    setBtn(0, 1, 0, 0, 0, 0);
    tick();
    @(negedge clk);
    setBtn(0, 0, 0, 1, 0, 0);
    tick();
    expectPhase(0, "R5 chop entry");
    for (int n = 1; n <= 4 * DIV; n++) begin
      tick();
      expectPhase((n / DIV) % 2, "R5 chop alternate");
    end

    // R6 chop three-way; trig toggle is a mode change
    @(negedge clk);
    setBtn(0, 0, 1, 1, 0, 0);
    tick();
    expectPhase(0, "R6 chop3 entry");
    for (int n = 1; n <= 6 * DIV; n++) begin
      tick();
      expectPhase((n / DIV) % 3, "R6 chop rotate");
    end

    // R10 restart collides with a chopper tick
    // currently 6*DIV edges in: next tick at edge 7*DIV
    for (int n = 6 * DIV + 1; n < 7 * DIV; n++) begin
      tick();
      expectPhase((n / DIV) % 3, "R6 chop rotate");
    end
    @(negedge clk);
    setBtn(0, 0, 0, 1, 0, 0);
    tick();
    expectPhase(0, "R10 restart beats chop tick");
    for (int n = 1; n <= DIV; n++) begin
      tick();
      expectPhase((n / DIV) % 2, "R10 full period after restart");
    end

    // R9 alt with chop: chopper must not step
    @(negedge clk);
    setBtn(0, 0, 0, 1, 1, 0);
    tick();
    expectPhase(0, "R9 alt over chop entry");
    for (int n = 0; n < 3 * DIV; n++) begin
      tick();
      expectPhase(0, "R9 no chop steps in alt R7");
    end

    // R7 alt two-way with varied pulse lengths
    steps = 0;
    for (int len = 1; len <= 4; len++) begin
      altBurst(len, len, 2, "R7 alt edge step");
    end

    // R8 alt three-way
    @(negedge clk);
    setBtn(0, 0, 1, 0, 1, 0);
    tick();
    expectPhase(0, "R8 alt3 entry");
    steps = 0;
    for (int k = 0; k < 7; k++) begin
      altBurst(1 + (k % 3), 2, 3, "R8 alt rotate");
    end

    // R10 restart collides with an alt rising edge
    @(negedge clk);
    setBtn(0, 0, 0, 0, 1, 0);
    tick();
    steps = 0;
    altBurst(1, 1, 2, "R7 alt step to B");
    @(negedge clk);
    setBtn(0, 0, 1, 0, 1, 0);
    altPulse = 1'b1;
    tick();
    expectPhase(0, "R10 restart beats alt edge");
    for (int i = 0; i < 3; i++) begin
      tick();
      expectPhase(0, "R10 held pulse no step");
    end
    @(negedge clk); altPulse = 0;

    // R1 reset mid-sequence in chop3
    setBtn(0, 0, 1, 1, 0, 0);
    for (int n = 0; n <= 2 * DIV; n++) tick();
    expectPhase(2, "R6 chop reaches trig");
    @(negedge clk); rst = 1'b1;
    tick();
    expect4(1, 0, 0, 0, "R1 reset mid-sequence");
    @(negedge clk); rst = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule